// File: doc/BRIEF.md
# Priority Agent Bus Takeover Controller

This block lets a high-priority agent, such as a system chipset, take a shared request bus away from a processor that may be driving it at the moment. When its own logic asks for the bus, the controller pulls an active-low priority request. It then watches the active-low address strobe and bus lock lines during the first clock of that request. From them it picks how long to wait before it enables its drivers on the address, address parity, request command and request parity lines.

Two waits are possible. The normal wait is a parameter of at least three clocks. A two-clock shortcut applies when the processor is seen starting an unlocked request in the first priority clock. Whichever wait is chosen, the clock just before the controller's drivers turn on is left undriven, so the outgoing and incoming owners never overlap. Once its own request completes, the controller drives the lines to their inactive levels for one clock and then lets go of them. Separately, the block qualifies the memory-type field of every observed request by its transaction type, so that I/O and special cycles are never taken as cacheable.

Top module: `bus_takeover_ctrl`

## Requirements
- R1: `rst` is synchronous and active high. The clock after a reset edge shows `prio_n`=1, `drv_oe`=0, `drv_idle`=0, `bus_owned`=0, `contention_err`=0 and `mt_strobe`=0. A reset during arbitration drops the request.
- R2: When `take_req`=1 while idle, `prio_n` goes low on the next clock and stays low through ownership and the release clock. `prio_n` returns high when the controller is idle again. `take_req` has no effect unless the controller is idle.
- R3: Call the first clock with `prio_n` low cycle 0. Without the shortcut, `drv_oe` and `bus_owned` rise in cycle DEF_LAT. `drv_oe` is low in cycle DEF_LAT-1, which is the dead turnaround clock.
- R4: If `ads_n`=0 and `lock_n`=1 in cycle 0, `drv_oe` rises in cycle 2, and cycle 1 is the dead clock.
- R5: If `lock_n`=0 in cycle 0, the wait is DEF_LAT even when `ads_n`=0. Strobe and lock values after cycle 0 never change the wait.
- R6: If `ads_n`=0 during the dead clock, `contention_err` rises in the same cycle as `drv_oe` and stays high until reset.
- R7: `own_done`=1 while owning gives one release clock next, with `drv_oe`=1, `drv_idle`=1 and `bus_owned`=0. The clock after that has `drv_oe`=0 and `prio_n`=1.
- R8: Each clock with `ads_n`=0 gives `mt_strobe`=1 one clock later. If `req_type` was 0 (memory read) or 1 (memory write), that clock also shows `mt_valid`=1 and `mt_attr` equal to the sampled `req_mt`.
- R9: For `req_type` 2 (I/O read), 3 (I/O write), 4 (special cycle) or 5 to 7 (reserved), the qualified result has `mt_valid`=0 and `mt_attr`=UC_CODE (default 0), whatever `req_mt` held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| take_req | input | 1 | Internal request to acquire the bus |
| own_done | input | 1 | The controller's own request has completed |
| ads_n | input | 1 | Observed address strobe, active low |
| lock_n | input | 1 | Observed bus lock, active low |
| req_type | input | 3 | Transaction type of the observed request |
| req_mt | input | MT_W | Memory-type field of the observed request |
| prio_n | output | 1 | Priority bus request, active low |
| drv_oe | output | 1 | Output enable for the request-phase lines |
| drv_idle | output | 1 | Drive the request lines to inactive levels (release clock) |
| bus_owned | output | 1 | The controller owns the bus for its request |
| contention_err | output | 1 | Strobe seen during the dead clock (sticky) |
| mt_strobe | output | 1 | Qualified memory-type result present |
| mt_valid | output | 1 | Memory-type field is meaningful |
| mt_attr | output | MT_W | Qualified memory type |

## Verification
The priority request appears one clock after `take_req`. The output enable follows that first priority clock by exactly two or DEF_LAT clocks, and the bench measures this gap in clocks and compares it with the wait each requirement names. The contention flag rises in the same clock as the output enable. The release clock comes one clock after `own_done`, and the memory-type result appears one clock after a strobe. The behavioural model in the bench advances on each rising edge from the inputs held across it, so every expected value carries this same register delay. Outputs are compared on the falling edge that follows.

// File: rtl/bto_pkg.sv
package bto_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ARB  = 2'd1,
    PH_OWN  = 2'd2,
    PH_REL  = 2'd3
  } bto_phase_e;

  localparam int unsigned REQ_TYPE_W = 3;
  localparam int unsigned FAST_LAT   = 2;

  // Wait from first priority clock to first driving clock.
  function automatic int unsigned pick_latency(input logic fast, input int unsigned def_lat);
    return fast ? FAST_LAT : def_lat;
  endfunction

  // Types 0 and 1 are memory accesses; everything else is not.
  function automatic logic type_is_memory(input logic [REQ_TYPE_W-1:0] t);
    return (t[REQ_TYPE_W-1:1] == '0);
  endfunction

endpackage

// File: rtl/bto_lat_timer.sv
module bto_lat_timer import bto_pkg::*; #(
  parameter int unsigned DEF_LAT = 4,
  parameter int unsigned CNT_W   = $clog2(DEF_LAT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic ads_n,
  input  logic lock_n,
  output logic expire,
  output logic first_clk
);

  logic [CNT_W-1:0] cnt_q;
  logic             fast_q;
  logic             fast_now;
  logic [CNT_W-1:0] lat_cur;

  assign first_clk = run && (cnt_q == '0);
  assign fast_now  = !ads_n && lock_n;
  assign lat_cur   = first_clk ? CNT_W'(pick_latency(fast_now, DEF_LAT))
                               : CNT_W'(pick_latency(fast_q, DEF_LAT));
  assign expire    = run && (cnt_q == lat_cur - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q  <= '0;
      fast_q <= 1'b0;
    end else begin
      if (first_clk) fast_q <= fast_now;
      if (!expire)   cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  // R4
  fast_takeover_chk: assert property (@(posedge clk) disable iff (rst)
    (first_clk && !ads_n && lock_n) |=> expire);

  // R5
  locked_no_shortcut_chk: assert property (@(posedge clk) disable iff (rst)
    (first_clk && !lock_n) |=> !expire);

endmodule

// File: rtl/bto_own_fsm.sv
module bto_own_fsm import bto_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       take_req,
  input  logic       expire,
  input  logic       own_done,
  input  logic       ads_n,
  output bto_phase_e phase,
  output logic       err
);

  bto_phase_e phase_d;
  logic       clash;

  assign clash = (phase == PH_ARB) && expire && !ads_n;

  always_comb begin
    phase_d = phase;
    case (phase)
      PH_IDLE: if (take_req) phase_d = PH_ARB;
      PH_ARB:  if (expire)   phase_d = PH_OWN;
      PH_OWN:  if (own_done) phase_d = PH_REL;
      PH_REL:                phase_d = PH_IDLE;
      default:               phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      err   <= 1'b0;
    end else begin
      phase <= phase_d;
      if (clash) err <= 1'b1;
    end
  end

  // R6
  err_at_takeover_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> (phase == PH_OWN) && ($past(phase) == PH_ARB));

  // R7
  release_one_clock_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_REL) |=> (phase == PH_IDLE));

endmodule

// File: rtl/bto_mtype_qual.sv
module bto_mtype_qual import bto_pkg::*; #(
  parameter int unsigned   MT_W    = 3,
  parameter logic [MT_W-1:0] UC_CODE = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ads_n,
  input  logic [REQ_TYPE_W-1:0] req_type,
  input  logic [MT_W-1:0]       req_mt,
  output logic                  strobe,
  output logic                  valid,
  output logic [MT_W-1:0]       attr
);

  logic is_mem;
  assign is_mem = type_is_memory(req_type);

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe <= 1'b0;
      valid  <= 1'b0;
      attr   <= UC_CODE;
    end else begin
      strobe <= !ads_n;
      valid  <= !ads_n && is_mem;
      attr   <= (!ads_n && is_mem) ? req_mt : UC_CODE;
    end
  end

  // R8
  valid_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    valid |-> strobe);

  // R9
  nonmem_uc_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe && !valid) |-> (attr == UC_CODE));

endmodule

// File: rtl/bus_takeover_ctrl.sv
module bus_takeover_ctrl import bto_pkg::*; #(
  parameter int unsigned     DEF_LAT = 4,
  parameter int unsigned     MT_W    = 3,
  parameter logic [MT_W-1:0] UC_CODE = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  take_req,
  input  logic                  own_done,
  input  logic                  ads_n,
  input  logic                  lock_n,
  input  logic [REQ_TYPE_W-1:0] req_type,
  input  logic [MT_W-1:0]       req_mt,
  output logic                  prio_n,
  output logic                  drv_oe,
  output logic                  drv_idle,
  output logic                  bus_owned,
  output logic                  contention_err,
  output logic                  mt_strobe,
  output logic                  mt_valid,
  output logic [MT_W-1:0]       mt_attr
);

  initial begin
    min_default_latency_chk: assert (DEF_LAT >= 3);
  end

  bto_phase_e phase;
  logic       arb_run;
  logic       arb_expire;
  logic       arb_first;

  assign arb_run = (phase == PH_ARB);

  bto_lat_timer #(.DEF_LAT(DEF_LAT)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .run       (arb_run),
    .ads_n     (ads_n),
    .lock_n    (lock_n),
    .expire    (arb_expire),
    .first_clk (arb_first)
  );

  bto_own_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .take_req (take_req),
    .expire   (arb_expire),
    .own_done (own_done),
    .ads_n    (ads_n),
    .phase    (phase),
    .err      (contention_err)
  );

  bto_mtype_qual #(.MT_W(MT_W), .UC_CODE(UC_CODE)) u_mtq (
    .clk      (clk),
    .rst      (rst),
    .ads_n    (ads_n),
    .req_type (req_type),
    .req_mt   (req_mt),
    .strobe   (mt_strobe),
    .valid    (mt_valid),
    .attr     (mt_attr)
  );

  assign prio_n    = (phase == PH_IDLE);
  assign drv_oe    = (phase == PH_OWN) || (phase == PH_REL);
  assign drv_idle  = (phase == PH_REL);
  assign bus_owned = (phase == PH_OWN);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (prio_n && !drv_oe && !contention_err && !mt_strobe));

  // R2
  prio_first_chk: assert property (@(posedge clk) disable iff (rst)
    arb_first |-> !prio_n && !drv_oe);

  // R3
  dead_clock_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_oe) |-> !$past(prio_n) && !$past(prio_n, 2));

  // R7
  release_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(drv_oe) |-> $past(drv_idle) && prio_n);

endmodule

// File: tb/tb_bus_takeover_ctrl.sv
`timescale 1ns/1ps
module tb_bus_takeover_ctrl;

  localparam int DEF_LAT = 4;
  localparam int MT_W    = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, take_req = 1'b0, own_done = 1'b0, ads_n = 1'b1, lock_n = 1'b1;
  logic [2:0] req_type = '0;
  logic [MT_W-1:0] req_mt = '0;
  logic prio_n, drv_oe, drv_idle, bus_owned, contention_err, mt_strobe, mt_valid;
  logic [MT_W-1:0] mt_attr;

  bus_takeover_ctrl #(.DEF_LAT(DEF_LAT), .MT_W(MT_W), .UC_CODE('0)) dut (
    .clk(clk), .rst(rst), .take_req(take_req), .own_done(own_done),
    .ads_n(ads_n), .lock_n(lock_n), .req_type(req_type), .req_mt(req_mt),
    .prio_n(prio_n), .drv_oe(drv_oe), .drv_idle(drv_idle), .bus_owned(bus_owned),
    .contention_err(contention_err), .mt_strobe(mt_strobe), .mt_valid(mt_valid),
    .mt_attr(mt_attr)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit cmp_en  = 1'b0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: 0 idle, 1 waiting, 2 owning, 3 releasing
  int m_phase = 0, m_k = 0, m_lat = DEF_LAT;
  bit m_err = 0, e_strobe = 0, e_valid = 0;
  int e_attr = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_k = 0; m_err = 0;
      e_strobe = 0; e_valid = 0; e_attr = 0;
    end else begin
      case (m_phase)
        0: if (take_req) begin m_phase = 1; m_k = 0; end
        1: begin
          if (m_k == 0) m_lat = (!ads_n && lock_n) ? 2 : DEF_LAT;
          if (m_k == m_lat - 1) begin
            if (!ads_n) m_err = 1;
            m_phase = 2;
          end else m_k++;
        end
        2: if (own_done) m_phase = 3;
        default: m_phase = 0;
      endcase
      e_strobe = !ads_n;
      e_valid  = !ads_n && (req_type <= 1);
      e_attr   = e_valid ? int'(req_mt) : 0;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      check("R2", "prio_n", prio_n, m_phase == 0);
      check("R3", "drv_oe", drv_oe, m_phase >= 2);
      check("R7", "bus_owned", bus_owned, m_phase == 2);
      check("R7", "drv_idle", drv_idle, m_phase == 3);
      check("R6", "contention_err", contention_err, m_err);
      check("R8", "mt_strobe", mt_strobe, e_strobe);
      check("R8", "mt_valid", mt_valid, e_valid);
      check((e_strobe && !e_valid) ? "R9" : "R8", "mt_attr", int'(mt_attr), e_attr);
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic takeover(input bit a0, input bit l0, input bit a1, input int exp_lat,
                          input string tag);
    int lat = -1;
    take_req = 1'b1;
    tick();
    take_req = 1'b0;
    ads_n  = !a0;
    lock_n = !l0;
    for (int c = 0; c < 12; c++) begin
      if (drv_oe && lat < 0) lat = c;
      if (c == 9)  take_req = 1'b1;
      if (c == 10) take_req = 1'b0;
      tick();
      ads_n  = (c == 0) ? !a1 : 1'b1;
      lock_n = 1'b1;
    end
    check(tag, "takeover latency", lat, exp_lat);
    check("R2", "late take_req ignored, still owning", bus_owned, 1);
    own_done = 1'b1;
    tick();
    own_done = 1'b0;
    check("R7", "release clock drv_idle", drv_idle, 1);
    check("R7", "release clock drv_oe", drv_oe, 1);
    tick();
    check("R7", "after release drv_oe", drv_oe, 0);
    check("R7", "after release prio_n", prio_n, 1);
    tick();
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    check("R1", "reset prio_n", prio_n, 1);
    check("R1", "reset drv_oe", drv_oe, 0);
    check("R1", "reset err", contention_err, 0);
    check("R1", "reset mt_strobe", mt_strobe, 0);
    cmp_en = 1'b1;
    tick();

    takeover(1'b0, 1'b0, 1'b0, DEF_LAT, "R3");
    takeover(1'b1, 1'b0, 1'b0, 2, "R4");
    takeover(1'b1, 1'b1, 1'b0, DEF_LAT, "R5");
    takeover(1'b0, 1'b0, 1'b1, DEF_LAT, "R5");
    check("R6", "no contention yet", contention_err, 0);
    takeover(1'b1, 1'b0, 1'b1, 2, "R4");
    check("R6", "contention flagged", contention_err, 1);

    rst = 1'b1;
    tick();
    rst = 1'b0;
    check("R1", "err cleared by reset", contention_err, 0);

    take_req = 1'b1;
    tick();
    take_req = 1'b0;
    check("R2", "prio asserted", prio_n, 0);
    tick();
    rst = 1'b1;
    tick();
    rst = 1'b0;
    check("R1", "reset mid-wait prio_n", prio_n, 1);
    check("R1", "reset mid-wait drv_oe", drv_oe, 0);
    tick();

    for (int t = 0; t < 8; t++) begin
      for (int m = 3; m < 8; m += 2) begin
        ads_n = 1'b0; req_type = 3'(t); req_mt = MT_W'(m);
        tick();
        ads_n = 1'b1;
        check("R8", "strobe after request", mt_strobe, 1);
        if (t <= 1) begin
          check("R8", "memory valid", mt_valid, 1);
          check("R8", "memory attr", int'(mt_attr), m);
        end else begin
          check("R9", "nonmemory invalid", mt_valid, 0);
          check("R9", "nonmemory attr UC", int'(mt_attr), 0);
        end
        tick();
        check("R8", "no strobe without request", mt_strobe, 0);
      end
    end
    req_type = '0; req_mt = '0;
    check("R2", "idle after sweep", prio_n, 1);
    tick();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule